// File: doc/BRIEF.md
# External Data Memory Access Controller

This block sits between an 8-bit microcontroller core and its data memories. It decides where each data-move access goes and runs the bus cycle for it. The core hands over one request at a time: an address, write data, a read/write flag and a flag that marks a code fetch. The block sends the access either to an on-chip RAM, whose usable size is chosen at run time, or to an external bus. On the external bus, the low address byte and the data share the same pins.

A single auxiliary control byte sets the behaviour, and the core reads and writes it over a simple special-function-register bus. The byte holds the following settings:
- which memory data accesses go to;
- how much of the on-chip RAM is used;
- whether the read and write strobes are short or stretched;
- whether the address-latch-enable output runs freely or only during accesses;
- whether the port weak pull-ups are switched off.

An access to on-chip RAM finishes in the same cycle it is presented. An external access runs as three phases: an address phase with an address-latch-enable pulse, then a strobe phase, then a one-cycle completion pulse.

Top module: `xmem_access_ctrl`

## Requirements
- R1: The control byte answers only at register-bus address 8Eh. A write there stores the whole byte. A read there returns it. Reads at any other address return 0, and writes at any other address change nothing.
- R2: Bits 6 and 4 of the control byte always read as 0, whatever value was written. The other bits (7, 5, 3:2, 1, 0) read back as written.
- R3: During reset, bits 7, 5, 3:2 and 0 clear to 0, and bit 1 (the external-select bit) takes the value of the `sec_ext_sel` input.
- R4: `weak_pullup_en` is the inverse of control bit 7.
- R5: An access is internal when all of the following hold: control bit 1 is 0, the access is not a code fetch, and the address is below the on-chip limit. Bits 3:2 set that limit: 00 gives 256 bytes, 01 gives 512, 10 gives 768 and 11 gives 1024. For an internal access, `iram_en`, `req_done` and the read data appear in the same cycle the request is presented. `iram_addr` is the low 10 address bits. No strobe and no address-latch-enable pulse occur.
- R6: An access goes to the external bus if any of the following hold: the address is at or above the on-chip limit, control bit 1 is 1, or `req_code` is 1.
- R7: An external access runs in a fixed order:
  - In the first cycle after acceptance, `ale` is 1, `ext_ad_out` carries the low address byte with `ext_ad_oe` high, and `ext_addr_hi` carries the high byte.
  - Next comes the strobe phase.
  - `req_done` is high for exactly one cycle, straight after the last strobe cycle.
- R8: The strobe lasts 6 clock cycles when control bit 5 is 0 and 30 when it is 1.
- R9: A write drives `wr_n` low, with the write data on `ext_ad_out` and `ext_ad_oe` high. A read drives `rd_n` low with `ext_ad_oe` low. The value on `ext_ad_in` in the last strobe cycle is returned on `req_rdata` along with `req_done`.
- R10: With control bit 0 at 0 and no access in progress, `ale` pulses once every 6 cycles, or once every 3 cycles when `x2_mode` is 1.
- R11: With control bit 0 at 1, `ale` stays low whenever no external access is in progress.
- R12: A code fetch always uses the read strobe. `wr_n` never goes low for a code fetch, even when `req_write` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x2_mode | input | 1 | Double-speed mode, halves the free address-latch-enable period |
| sec_ext_sel | input | 1 | Security-byte value loaded into the external-select bit at reset |
| sfr_addr | input | 8 | Register-bus address |
| sfr_wr | input | 1 | Register-bus write enable |
| sfr_wdata | input | 8 | Register-bus write data |
| sfr_rdata | output | 8 | Register-bus read data (combinational) |
| req_valid | input | 1 | Access request, held until `req_done` |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Access write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_code | input | 1 | 1 = code fetch |
| req_done | output | 1 | Access complete pulse |
| req_rdata | output | 8 | Read data, valid with `req_done` |
| iram_en | output | 1 | On-chip RAM select |
| iram_we | output | 1 | On-chip RAM write enable |
| iram_addr | output | 10 | On-chip RAM address |
| iram_wdata | output | 8 | On-chip RAM write data |
| iram_rdata | input | 8 | On-chip RAM read data (combinational) |
| ext_ad_out | output | 8 | Multiplexed low address / data out |
| ext_ad_oe | output | 1 | Drive enable for the multiplexed pins |
| ext_ad_in | input | 8 | Multiplexed data in |
| ext_addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address-latch-enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| weak_pullup_en | output | 1 | Request for permanent weak pull-ups |

## Verification
The hardest case to reach from the ports is the routing boundary. Whether an address stays on chip depends both on the size field and on the exact address at the edge of the on-chip limit. The bench reprograms the size field to each of its four codes. For each code it presents the last on-chip address and the first address above it, and checks which side of the bus responds. A second hard case is the interplay between the free-running address-latch-enable and an external access in progress: the bench counts `ale` pulses across whole access windows in both control settings, so a stray pulse during a strobe is caught.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  localparam int BIT_PU_DIS  = 7;
  localparam int BIT_STRETCH = 5;
  localparam int BIT_SIZE_HI = 3;
  localparam int BIT_SIZE_LO = 2;
  localparam int BIT_EXT     = 1;
  localparam int BIT_ALE     = 0;
  localparam logic [7:0] CFG_WMASK = 8'b1010_1111;

  typedef struct packed {
    logic       pu_dis;
    logic       stretch;
    logic [1:0] size;
    logic       ext_sel;
    logic       ale_on_access;
  } cfg_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADDR = 2'd1,
    SEQ_STRB = 2'd2,
    SEQ_DONE = 2'd3
  } seq_state_e;

  // Byte count of on-chip RAM selected by the size code.
  function automatic int unsigned onchip_limit(input logic [1:0] size_code,
                                               input int unsigned page_bytes);
    return (32'(size_code) + 32'd1) * page_bytes;
  endfunction

  function automatic logic onchip_hit(input int unsigned addr,
                                      input logic [1:0] size_code,
                                      input int unsigned page_bytes);
    return addr < onchip_limit(size_code, page_bytes);
  endfunction

  function automatic int unsigned strobe_cycles(input logic stretch,
                                                input int unsigned short_len,
                                                input int unsigned long_len);
    return stretch ? long_len : short_len;
  endfunction

endpackage

// File: rtl/xmem_cfg_reg.sv
module xmem_cfg_reg
  import xmem_pkg::*;
#(
  parameter logic [7:0] SFR_ADDR = 8'h8E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_ext_sel,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  output cfg_t       cfg
);

  logic [7:0] reg_q;
  logic       hit;

  assign hit = (sfr_addr == SFR_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q          <= '0;
      reg_q[BIT_EXT] <= sec_ext_sel;
    end else if (sfr_wr && hit) begin
      reg_q <= sfr_wdata & CFG_WMASK;
    end
  end

  assign sfr_rdata = hit ? reg_q : 8'h00;

  assign cfg.pu_dis        = reg_q[BIT_PU_DIS];
  assign cfg.stretch       = reg_q[BIT_STRETCH];
  assign cfg.size          = reg_q[BIT_SIZE_HI:BIT_SIZE_LO];
  assign cfg.ext_sel       = reg_q[BIT_EXT];
  assign cfg.ale_on_access = reg_q[BIT_ALE];

endmodule

// File: rtl/xmem_ale_gen.sv
module xmem_ale_gen #(
  parameter int DIV    = 6,
  parameter int DIV_X2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x2_mode,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST    = CW'(DIV - 1);
  localparam logic [CW-1:0] LAST_X2 = CW'(DIV_X2 - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = x2_mode ? LAST_X2 : LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q >= last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == '0);

endmodule

// File: rtl/xmem_bus_seq.sv
module xmem_bus_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SHORT_LEN = 6,
  parameter int LONG_LEN  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              write,
  input  logic              stretch,
  input  logic [DATA_W-1:0] bus_in,
  output logic              busy,
  output logic              addr_phase,
  output logic              strobe_last,
  output logic              long_q,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  localparam int CW = $clog2(LONG_LEN + 1);

  seq_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;
  logic              in_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      long_q  <= 1'b0;
      rdata   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            addr_q  <= addr;
            wdata_q <= wdata;
            wr_q    <= write;
            long_q  <= stretch;
            state_q <= SEQ_ADDR;
          end
        end
        SEQ_ADDR: begin
          cnt_q   <= CW'(strobe_cycles(long_q, SHORT_LEN, LONG_LEN) - 1);
          state_q <= SEQ_STRB;
        end
        SEQ_STRB: begin
          if (strobe_last) begin
            if (!wr_q) rdata <= bus_in;
            state_q <= SEQ_DONE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_DONE: state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != SEQ_IDLE);
  assign addr_phase  = (state_q == SEQ_ADDR);
  assign in_strobe   = (state_q == SEQ_STRB);
  assign strobe_last = in_strobe && (cnt_q == '0);
  assign done        = (state_q == SEQ_DONE);

  assign rd_n    = !(in_strobe && !wr_q);
  assign wr_n    = !(in_strobe && wr_q);
  assign bus_oe  = addr_phase || (in_strobe && wr_q);
  assign bus_out = addr_phase ? addr_q[DATA_W-1:0] :
                   (in_strobe && wr_q) ? wdata_q : '0;
  assign addr_hi = addr_q[ADDR_W-1:DATA_W];

endmodule

// File: rtl/xmem_access_ctrl.sv
module xmem_access_ctrl
  import xmem_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         DATA_W     = 8,
  parameter int         IRAM_AW    = 10,
  parameter int         PAGE_BYTES = 256,
  parameter logic [7:0] SFR_ADDR   = 8'h8E,
  parameter int         SHORT_LEN  = 6,
  parameter int         LONG_LEN   = 30,
  parameter int         ALE_DIV    = 6,
  parameter int         ALE_DIV_X2 = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     x2_mode,
  input  logic                     sec_ext_sel,
  input  logic [7:0]               sfr_addr,
  input  logic                     sfr_wr,
  input  logic [7:0]               sfr_wdata,
  output logic [7:0]               sfr_rdata,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_write,
  input  logic                     req_code,
  output logic                     req_done,
  output logic [DATA_W-1:0]        req_rdata,
  output logic                     iram_en,
  output logic                     iram_we,
  output logic [IRAM_AW-1:0]       iram_addr,
  output logic [DATA_W-1:0]        iram_wdata,
  input  logic [DATA_W-1:0]        iram_rdata,
  output logic [DATA_W-1:0]        ext_ad_out,
  output logic                     ext_ad_oe,
  input  logic [DATA_W-1:0]        ext_ad_in,
  output logic [ADDR_W-DATA_W-1:0] ext_addr_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     weak_pullup_en
);

  cfg_t              cfg;
  logic              ale_tick;
  logic              seq_busy;
  logic              seq_addr_phase;
  logic              seq_strobe_last;
  logic              seq_long;
  logic              seq_done;
  logic [DATA_W-1:0] seq_rdata;
  logic              route_ext;
  logic              ext_start;
  logic              ext_write;
  logic              ale_on_access_w;

  xmem_cfg_reg #(.SFR_ADDR(SFR_ADDR)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_ext_sel (sec_ext_sel),
    .sfr_addr    (sfr_addr),
    .sfr_wr      (sfr_wr),
    .sfr_wdata   (sfr_wdata),
    .sfr_rdata   (sfr_rdata),
    .cfg         (cfg)
  );

  xmem_ale_gen #(.DIV(ALE_DIV), .DIV_X2(ALE_DIV_X2)) u_ale (
    .clk     (clk),
    .rst_n   (rst_n),
    .x2_mode (x2_mode),
    .tick    (ale_tick)
  );

  // Routing decision: code fetches, external select, or beyond the limit.
  assign route_ext = req_code || cfg.ext_sel ||
                     !onchip_hit(32'(req_addr), cfg.size, PAGE_BYTES);
  assign ext_start = req_valid && !seq_busy && route_ext;
  assign ext_write = req_write && !req_code;

  xmem_bus_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (ext_start),
    .addr        (req_addr),
    .wdata       (req_wdata),
    .write       (ext_write),
    .stretch     (cfg.stretch),
    .bus_in      (ext_ad_in),
    .busy        (seq_busy),
    .addr_phase  (seq_addr_phase),
    .strobe_last (seq_strobe_last),
    .long_q      (seq_long),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .bus_out     (ext_ad_out),
    .bus_oe      (ext_ad_oe),
    .addr_hi     (ext_addr_hi),
    .done        (seq_done),
    .rdata       (seq_rdata)
  );

  assign iram_en    = req_valid && !seq_busy && !route_ext;
  assign iram_we    = iram_en && req_write;
  assign iram_addr  = req_addr[IRAM_AW-1:0];
  assign iram_wdata = req_wdata;

  assign req_done  = iram_en || seq_done;
  assign req_rdata = iram_en ? iram_rdata : seq_rdata;

  assign ale_on_access_w = cfg.ale_on_access;
  assign ale = seq_addr_phase || (!ale_on_access_w && ale_tick && !seq_busy);
  assign weak_pullup_en = !cfg.pu_dis;

endmodule

// File: rtl/xmem_access_ctrl_chk.sv
module xmem_access_ctrl_chk #(
  parameter int SHORT_LEN = 6,
  parameter int LONG_LEN  = 30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       req_done,
  input logic       iram_en,
  input logic       seq_busy,
  input logic       seq_long,
  input logic       seq_strobe_last,
  input logic       ale_on_access,
  input logic [7:0] sfr_rdata
);

  localparam int CW = $clog2(LONG_LEN + 2);

  logic          strobe;
  logic [CW-1:0] run_q;

  assign strobe = !rd_n || !wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (strobe) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R8: a finished strobe run has the programmed length
  a_r8_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && run_q != '0) |->
      (run_q == (seq_long ? CW'(LONG_LEN) : CW'(SHORT_LEN))));

  // R9: never both strobes at once
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R7: no address-latch pulse during a strobe
  a_r7_ale_quiet_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !ale);

  // R7: external completion follows the last strobe cycle
  a_r7_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    seq_strobe_last |=> (req_done && !strobe));

  // R5: on-chip access completes in its own cycle with no strobe
  a_r5_onchip_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    iram_en |-> (req_done && !strobe && !seq_busy));

  // R11: access-only mode keeps ale low while idle
  a_r11_ale_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_on_access && !seq_busy) |-> !ale);

  // R2: reserved bits read as zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rdata[6] == 1'b0) && (sfr_rdata[4] == 1'b0));

endmodule

bind xmem_access_ctrl xmem_access_ctrl_chk #(
  .SHORT_LEN (SHORT_LEN),
  .LONG_LEN  (LONG_LEN)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ale             (ale),
  .rd_n            (rd_n),
  .wr_n            (wr_n),
  .req_done        (req_done),
  .iram_en         (iram_en),
  .seq_busy        (seq_busy),
  .seq_long        (seq_long),
  .seq_strobe_last (seq_strobe_last),
  .ale_on_access   (ale_on_access_w),
  .sfr_rdata       (sfr_rdata)
);

// File: tb/xmem_access_ctrl_test.sv
module xmem_access_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        x2_mode = 1'b0;
  logic        sec_ext_sel = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        req_write = 1'b0;
  logic        req_code = 1'b0;
  logic        req_done;
  logic [7:0]  req_rdata;
  logic        iram_en, iram_we;
  logic [9:0]  iram_addr;
  logic [7:0]  iram_wdata, iram_rdata;
  logic [7:0]  ext_ad_out;
  logic        ext_ad_oe;
  logic [7:0]  ext_ad_in = 8'h00;
  logic [7:0]  ext_addr_hi;
  logic        ale, rd_n, wr_n, weak_pullup_en;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  assign iram_rdata = iram_addr[7:0] ^ 8'hA5;

  xmem_access_ctrl uut (
    .clk(clk), .rst_n(rst_n), .x2_mode(x2_mode), .sec_ext_sel(sec_ext_sel),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .req_code(req_code), .req_done(req_done), .req_rdata(req_rdata),
    .iram_en(iram_en), .iram_we(iram_we), .iram_addr(iram_addr),
    .iram_wdata(iram_wdata), .iram_rdata(iram_rdata),
    .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe), .ext_ad_in(ext_ad_in),
    .ext_addr_hi(ext_addr_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .weak_pullup_en(weak_pullup_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic sec);
    rst_n = 1'b0;
    sec_ext_sel = sec;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    step();
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_expect(input logic [7:0] a, input logic [7:0] exp, input string req);
    sfr_addr = a;
    #1;
    check(sfr_rdata == exp, req, sfr_rdata, exp);
  endtask

  // Internal access: everything happens in the presentation cycle.
  task automatic int_access(input logic [15:0] a, input logic wr, input logic [7:0] d);
    req_addr = a; req_write = wr; req_wdata = d; req_code = 1'b0; req_valid = 1'b1;
    #1;
    check(iram_en && req_done, "R5 onchip en+done", {iram_en, req_done}, 2'b11);
    check(iram_addr == a[9:0], "R5 iram_addr", iram_addr, a[9:0]);
    check(iram_we == wr, "R5 iram_we", iram_we, wr);
    if (!wr) check(req_rdata == (a[7:0] ^ 8'hA5), "R5 read data", req_rdata, a[7:0] ^ 8'hA5);
    step();
    req_valid = 1'b0;
    check(rd_n && wr_n && !ale, "R5 no external activity", {rd_n, wr_n, ale}, 3'b110);
  endtask

  // External access: count address-latch, strobe and completion cycles.
  task automatic ext_access(input logic [15:0] a, input logic wr, input logic [7:0] d,
                            input logic code, input int len, input string req);
    int n_ale = 0, n_str = 0, done_at = 0;
    logic [7:0] got = 8'h00;
    bit bad_data = 1'b0, saw_wr = 1'b0;
    req_addr = a; req_write = wr; req_wdata = d; req_code = code; req_valid = 1'b1;
    ext_ad_in = a[7:0] ^ 8'h3C;
    #1;
    check(!iram_en, {req, " R6 not onchip"}, iram_en, 0);
    for (int i = 1; i <= 60; i++) begin
      step();
      if (i == 1) begin
        check(ale && ext_ad_oe && ext_ad_out == a[7:0] && ext_addr_hi == a[15:8],
              {req, " R7 address phase"}, {ale, ext_ad_oe, ext_ad_out, ext_addr_hi},
              {1'b1, 1'b1, a});
      end
      if (ale) n_ale++;
      if (!wr_n) saw_wr = 1'b1;
      if (!rd_n || !wr_n) begin
        n_str++;
        if (wr && !code && (!ext_ad_oe || ext_ad_out != d)) bad_data = 1'b1;
        if ((!wr || code) && ext_ad_oe) bad_data = 1'b1;
      end
      if (req_done) begin
        done_at = i;
        got = req_rdata;
        break;
      end
    end
    req_valid = 1'b0;
    check(n_ale == 1, {req, " R7 one ale pulse"}, n_ale, 1);
    check(n_str == len, {req, " R8 strobe length"}, n_str, len);
    check(done_at == len + 2, {req, " R7 done cycle"}, done_at, len + 2);
    check(!bad_data, {req, " R9 bus data/oe during strobe"}, bad_data, 0);
    if (code) check(!saw_wr, {req, " R12 no write strobe"}, saw_wr, 0);
    else      check(saw_wr == wr, {req, " R9 strobe kind"}, saw_wr, wr);
    if (!wr || code) check(got == (a[7:0] ^ 8'h3C), {req, " R9 read data"}, got, a[7:0] ^ 8'h3C);
    step();
    check(!req_done && rd_n && wr_n, {req, " R7 single done"}, req_done, 0);
  endtask

  task automatic count_ale(input int cycles, input int exp, input string req);
    int n = 0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (ale) n++;
    end
    check(n == exp, req, n, exp);
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    sfr_expect(8'h8E, 8'h02, "R3 reset with security bit set");
    check(weak_pullup_en == 1'b1, "R3 R4 pull-up after reset", weak_pullup_en, 1);
    ext_access(16'h0010, 1'b0, 8'h00, 1'b0, 6, "R6 ext_sel from reset");
    do_reset(1'b0);
    sfr_expect(8'h8E, 8'h00, "R3 reset with security bit clear");
  endtask

  task automatic t_sfr();
    sfr_write(8'h8E, 8'hFF);
    sfr_expect(8'h8E, 8'hAF, "R2 reserved bits read zero");
    check(weak_pullup_en == 1'b0, "R4 pull-up disabled", weak_pullup_en, 0);
    sfr_expect(8'h8F, 8'h00, "R1 other address reads zero");
    sfr_write(8'h8F, 8'h00);
    sfr_expect(8'h8E, 8'hAF, "R1 write elsewhere ignored");
    sfr_write(8'h8E, 8'h21);
    sfr_expect(8'h8E, 8'h21, "R1 byte write");
    check(weak_pullup_en == 1'b1, "R4 pull-up enabled", weak_pullup_en, 1);
  endtask

  task automatic t_routing();
    for (int s = 0; s < 4; s++) begin
      logic [15:0] lim = 16'((s + 1) * 256);
      sfr_write(8'h8E, 8'(s << 2) | 8'h01);
      int_access(lim - 16'd1, 1'b0, 8'h00);
      int_access(16'h0000, 1'b1, 8'h5A);
      ext_access(lim, 1'b0, 8'h00, 1'b0, 6, "R6 above limit");
    end
    sfr_write(8'h8E, 8'h0F);
    ext_access(16'h0010, 1'b0, 8'h00, 1'b0, 6, "R6 ext_sel set");
  endtask

  task automatic t_external();
    sfr_write(8'h8E, 8'h03);
    ext_access(16'h12C4, 1'b1, 8'h9B, 1'b0, 6, "R9 short write");
    sfr_write(8'h8E, 8'h23);
    ext_access(16'hA577, 1'b0, 8'h00, 1'b0, 30, "R8 long read");
    ext_access(16'h4001, 1'b1, 8'h66, 1'b0, 30, "R8 long write");
    sfr_write(8'h8E, 8'h00);
    ext_access(16'h0020, 1'b1, 8'h11, 1'b1, 6, "R12 code fetch");
    ext_access(16'h0800, 1'b0, 8'h00, 1'b0, 6, "R10 free ale mode access");
  endtask

  task automatic t_ale();
    sfr_write(8'h8E, 8'h00);
    x2_mode = 1'b0;
    repeat (8) step();
    count_ale(60, 10, "R10 free ale every 6");
    x2_mode = 1'b1;
    repeat (8) step();
    count_ale(60, 20, "R10 free ale every 3 in x2");
    x2_mode = 1'b0;
    sfr_write(8'h8E, 8'h01);
    count_ale(40, 0, "R11 ale quiet when idle");
  endtask

  initial begin
    #(2_000_000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_sfr();
    t_routing();
    t_external();
    t_ale();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule